// File: doc/BRIEF.md
# Microsequenced Accumulator Processor

This block is a compact processor with one accumulator, built around a single internal data bus. The registers on that bus are a program counter, a memory address register, an instruction register, the accumulator and an operand holding register that feeds the adder. They share the bus with a sixteen-word memory that holds both program and data. Every transfer is one bus source driving the bus while one or more registers capture it at the rising clock edge. A sequencer walks through a fixed ring of timing states. In each state it raises only active-high load and bus-drive strobes, chosen from the current state and the opcode held in the instruction register.

Each instruction is an 8-bit word. The opcode sits in the upper four bits and a 4-bit operand in the lower four. The operand is a memory address for load, add, indirect add and store, and a literal for the immediate add. Every instruction takes exactly eight timing states. The first three fetch the instruction word. The remaining five carry out the operation or idle. The memory contents come from a parameter image, which is copied into memory whenever reset is applied. A stop instruction parks the processor until the next reset, so data words that follow the program are never fetched as instructions.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous active-high reset sets the accumulator, program counter, halted flag and timing state to zero, and copies the parameter image into memory, with image bits [8*i+7:8*i] going to address i.
- R2: Outside the halted state, the timing state counts 0,1,...,7 and wraps, so every instruction takes eight clock cycles. The program counter advances by one, modulo 16, only at the edge that ends state 1.
- R3: An instruction word holds the opcode in bits [7:4] and the operand in bits [3:0]. Opcode 0 loads the memory word at the operand address into the accumulator.
- R4: Opcode 1 adds the memory word at the operand address to the accumulator, modulo 256.
- R5: Opcode 2 adds the operand, zero-extended to 8 bits, to the accumulator, modulo 256.
- R6: Opcode 3 reads the word at the operand address, takes its bits [3:0] as a second address, and adds the word at that second address to the accumulator, modulo 256.
- R7: Opcode 4 writes the accumulator to the memory word at the operand address and leaves the accumulator unchanged. Memory is written only at the edge that ends state 4.
- R8: Opcode F raises the halted flag at the edge that ends state 3 of that instruction. From then until reset, the timing state stays 0 and the accumulator and program counter do not change.
- R9: Opcodes 5 to E change neither the accumulator nor memory. The program counter still advances.
- R10: At most one source drives the internal bus in any state, and the accumulator changes only at edges that end states 4, 5 or 6.
- R11: With the image LOAD 4, ADD-INDIRECT 5, ADD-IMMEDIATE 6, STOP at addresses 0 to 3 and the words 5, 6, 7 at addresses 4 to 6, the accumulator reads 5, 12 and 18 after the first three instructions, and the processor then halts with the program counter at 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register captures on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_o | output | 8 | Accumulator value |
| pc_o | output | 4 | Program counter value |
| halted_o | output | 1 | High once a stop instruction has executed |
| state_o | output | 3 | Timing state about to execute (0 to 7) |

## Verification
The assertions check on every cycle that no more than one bus source is active, that the timing state steps by one or parks at zero, and that the program counter moves only at the end of state 1. They also check that the accumulator moves only in the three execute states, that memory is written only in state 4, and that the halted flag rises after state 3 and then holds. Only the bench scenarios can show the values the instructions compute. These include wrapping sums, indirect reads through a pointer word, a stored word that a later load reads back, opcodes with no effect, and programs that modify themselves. Reloading the memory image on a second reset is likewise visible only from a scenario.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int OPC_W   = DATA_W - ADDR_W;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int NSTATE  = 8;
    localparam int STATE_W = $clog2(NSTATE);
    localparam int IMG_W   = DATA_W * DEPTH;
    localparam int NSRC    = 5;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [OPC_W-1:0]  opc_t;

    typedef enum logic [STATE_W-1:0] {
        T0, T1, T2, T3, T4, T5, T6, T7
    } tstate_e;

    localparam opc_t OP_LOAD   = opc_t'(4'h0);
    localparam opc_t OP_ADD    = opc_t'(4'h1);
    localparam opc_t OP_ADDI   = opc_t'(4'h2);
    localparam opc_t OP_ADDIND = opc_t'(4'h3);
    localparam opc_t OP_STORE  = opc_t'(4'h4);
    localparam opc_t OP_STOP   = opc_t'(4'hF);

    // Strobes raised by the sequencer; *_en drive the bus, *_ld capture it.
    typedef struct packed {
        logic pc_en;
        logic pc_inc;
        logic mar_ld;
        logic ir_ld;
        logic ir_en;
        logic mem_en;
        logic mem_wr;
        logic acc_en;
        logic acc_ld;
        logic tmp_ld;
        logic alu_en;
        logic halt;
    } ctl_t;

    // Program used when no other image is given: load, indirect add,
    // immediate add, stop, followed by three data words.
    localparam logic [IMG_W-1:0] DEMO_IMAGE =
        128'h00000000_00000000_00070605_F0263504;

    function automatic opc_t op_of(word_t w);
        return w[DATA_W-1 -: OPC_W];
    endfunction

    function automatic addr_t arg_of(word_t w);
        return w[ADDR_W-1:0];
    endfunction

    function automatic word_t widen(addr_t a);
        return {{(DATA_W-ADDR_W){1'b0}}, a};
    endfunction

    // Microcode: strobes for one timing state of one opcode.
    function automatic ctl_t microstep(tstate_e st, opc_t op);
        ctl_t c;
        c = '0;
        case (st)
            T0: begin
                c.pc_en  = 1'b1;
                c.mar_ld = 1'b1;
            end
            T1: c.pc_inc = 1'b1;
            T2: begin
                c.mem_en = 1'b1;
                c.ir_ld  = 1'b1;
            end
            T3: begin
                case (op)
                    OP_LOAD, OP_ADD, OP_ADDIND, OP_STORE: begin
                        c.ir_en  = 1'b1;
                        c.mar_ld = 1'b1;
                    end
                    OP_ADDI: begin
                        c.ir_en  = 1'b1;
                        c.tmp_ld = 1'b1;
                    end
                    OP_STOP: c.halt = 1'b1;
                    default: ;
                endcase
            end
            T4: begin
                case (op)
                    OP_LOAD: begin
                        c.mem_en = 1'b1;
                        c.acc_ld = 1'b1;
                    end
                    OP_ADD: begin
                        c.mem_en = 1'b1;
                        c.tmp_ld = 1'b1;
                    end
                    OP_ADDIND: begin
                        c.mem_en = 1'b1;
                        c.mar_ld = 1'b1;
                    end
                    OP_ADDI: begin
                        c.alu_en = 1'b1;
                        c.acc_ld = 1'b1;
                    end
                    OP_STORE: begin
                        c.acc_en = 1'b1;
                        c.mem_wr = 1'b1;
                    end
                    default: ;
                endcase
            end
            T5: begin
                case (op)
                    OP_ADD: begin
                        c.alu_en = 1'b1;
                        c.acc_ld = 1'b1;
                    end
                    OP_ADDIND: begin
                        c.mem_en = 1'b1;
                        c.tmp_ld = 1'b1;
                    end
                    default: ;
                endcase
            end
            T6: begin
                if (op == OP_ADDIND) begin
                    c.alu_en = 1'b1;
                    c.acc_ld = 1'b1;
                end
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
    import acc_cpu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  opc_t    op,
    output ctl_t    ctl,
    output tstate_e state,
    output logic    halted
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= T0;
            halted <= 1'b0;
        end else if (!halted) begin
            if (ctl.halt) begin
                halted <= 1'b1;
                state  <= T0;
            end else begin
                state <= tstate_e'(state + 1'b1);
            end
        end
    end

    always_comb begin
        if (halted) begin
            ctl = '0;
        end else begin
            ctl = microstep(state, op);
        end
    end

endmodule

// File: rtl/acc_cpu_path.sv
module acc_cpu_path
    import acc_cpu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctl_t  ctl,
    input  word_t mem_rd,
    output word_t bus,
    output addr_t mar,
    output addr_t pc,
    output word_t acc,
    output opc_t  op
);

    word_t ir;
    word_t tmp;
    word_t alu_sum;
    word_t src [NSRC];
    logic [NSRC-1:0] sel;

    assign alu_sum = acc + tmp;

    assign src[0] = widen(pc);
    assign src[1] = widen(arg_of(ir));
    assign src[2] = mem_rd;
    assign src[3] = acc;
    assign src[4] = alu_sum;
    assign sel    = {ctl.alu_en, ctl.acc_en, ctl.mem_en, ctl.ir_en, ctl.pc_en};

    // AND-OR bus: the microcode enables at most one source per state.
    always_comb begin
        bus = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (sel[s]) begin
                bus = bus | src[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            mar <= '0;
            ir  <= '0;
            acc <= '0;
            tmp <= '0;
        end else begin
            if (ctl.pc_inc) pc  <= pc + 1'b1;
            if (ctl.mar_ld) mar <= arg_of(bus);
            if (ctl.ir_ld)  ir  <= bus;
            if (ctl.acc_ld) acc <= bus;
            if (ctl.tmp_ld) tmp <= bus;
        end
    end

    assign op = op_of(ir);

endmodule

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram
    import acc_cpu_pkg::*;
#(
    parameter logic [IMG_W-1:0] INIT_IMAGE = DEMO_IMAGE
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  addr_t addr,
    input  word_t wd,
    output word_t rd
);

    word_t cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : gen_cell
        word_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= INIT_IMAGE[g*DATA_W +: DATA_W];
            end else if (we && addr == addr_t'(g)) begin
                q <= wd;
            end
        end
        assign cells[g] = q;
    end

    assign rd = cells[addr];

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter logic [IMG_W-1:0] INIT_IMAGE = DEMO_IMAGE
) (
    input  logic               clk,
    input  logic               rst,
    output logic [DATA_W-1:0]  acc_o,
    output logic [ADDR_W-1:0]  pc_o,
    output logic               halted_o,
    output logic [STATE_W-1:0] state_o
);

    ctl_t    ctl;
    tstate_e state;
    logic    halted;
    opc_t    op;
    word_t   bus;
    word_t   mem_rd;
    addr_t   mar;
    addr_t   pc;
    word_t   acc;

    acc_cpu_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .ctl    (ctl),
        .state  (state),
        .halted (halted)
    );

    acc_cpu_path u_path (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .mem_rd (mem_rd),
        .bus    (bus),
        .mar    (mar),
        .pc     (pc),
        .acc    (acc),
        .op     (op)
    );

    acc_cpu_ram #(.INIT_IMAGE(INIT_IMAGE)) u_ram (
        .clk  (clk),
        .rst  (rst),
        .we   (ctl.mem_wr),
        .addr (mar),
        .wd   (bus),
        .rd   (mem_rd)
    );

    assign acc_o    = acc;
    assign pc_o     = pc;
    assign halted_o = halted;
    assign state_o  = state;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] acc,
    input logic [3:0] pc,
    input logic       halted,
    input logic [2:0] state,
    input logic [4:0] drv,
    input logic       wr
);

    // R10: a single bus source per state
    p_one_source_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv));

    // R10: accumulator moves only after states 4, 5, 6
    p_acc_window_r10: assert property (@(posedge clk) disable iff (rst)
        (halted || state < 3'd4 || state == 3'd7) |=> $stable(acc));

    // R2: program counter steps once, after state 1
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!halted && state == 3'd1) |=> pc == $past(pc) + 1'b1);

    p_pc_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (halted || state != 3'd1) |=> $stable(pc));

    // R2: timing state walks the ring unless the processor parks
    p_state_walk_r2: assert property (@(posedge clk) disable iff (rst)
        !halted |=> (halted ? state == 3'd0 : state == $past(state) + 1'b1));

    // R8: halt is sticky and parks the state at zero
    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && state == 3'd0));

    // R8: halt rises only after state 3
    p_halt_at_t3_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) |-> $past(state) == 3'd3);

    // R7: memory written only during state 4
    p_write_t4_r7: assert property (@(posedge clk) disable iff (rst)
        wr |-> state == 3'd4);

endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .acc    (acc_o),
    .pc     (pc_o),
    .halted (halted_o),
    .state  (state_o),
    .drv    ({ctl.pc_en, ctl.ir_en, ctl.mem_en, ctl.acc_en, ctl.alu_en}),
    .wr     (ctl.mem_wr)
);

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb;
    import acc_cpu_pkg::*;

    localparam int NI    = 4;
    localparam int STEPS = 20;
    localparam int WD    = 20000;

    function automatic logic [IMG_W-1:0] rand_image(input logic [31:0] seed);
        logic [31:0] s;
        logic [IMG_W-1:0] img;
        logic [3:0] hi;
        logic [3:0] op;
        s   = seed;
        img = '0;
        for (int i = 0; i < DEPTH; i++) begin
            s  = s ^ (s << 13);
            s  = s ^ (s >> 17);
            s  = s ^ (s << 5);
            hi = s[11:8];
            op = (hi >= 4'hB) ? hi : 4'(int'(hi) % 5);
            img[i*DATA_W +: DATA_W] = {op, s[3:0]};
        end
        return img;
    endfunction

    // Image B: wrap, no-op opcode, store and read back.
    // 0 LOAD C, 1 ADDI F, 2 ADD D, 3 5A, 4 ADD E, 5 STORE E, 6 LOAD E, 7 ADD E, 8 STOP
    localparam logic [IMG_W-1:0] IMG0 = DEMO_IMAGE;
    localparam logic [IMG_W-1:0] IMG1 =
        128'h00_11_03_F0_00_00_00_F0_1E_0E_4E_1E_5A_1D_2F_0C;
    localparam logic [IMG_W-1:0] IMG2 = rand_image(32'h1BADC0DE);
    localparam logic [IMG_W-1:0] IMG3 = rand_image(32'h00C0FFEE);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [7:0] acc_w   [NI];
    logic [3:0] pc_w    [NI];
    logic       halt_w  [NI];
    logic [2:0] state_w [NI];

    acc_cpu #(.INIT_IMAGE(IMG0)) u_dut (
        .clk(clk), .rst(rst), .acc_o(acc_w[0]), .pc_o(pc_w[0]),
        .halted_o(halt_w[0]), .state_o(state_w[0]));
    acc_cpu #(.INIT_IMAGE(IMG1)) u_dut_b (
        .clk(clk), .rst(rst), .acc_o(acc_w[1]), .pc_o(pc_w[1]),
        .halted_o(halt_w[1]), .state_o(state_w[1]));
    acc_cpu #(.INIT_IMAGE(IMG2)) u_dut_c (
        .clk(clk), .rst(rst), .acc_o(acc_w[2]), .pc_o(pc_w[2]),
        .halted_o(halt_w[2]), .state_o(state_w[2]));
    acc_cpu #(.INIT_IMAGE(IMG3)) u_dut_d (
        .clk(clk), .rst(rst), .acc_o(acc_w[3]), .pc_o(pc_w[3]),
        .halted_o(halt_w[3]), .state_o(state_w[3]));

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] m_mem  [NI][DEPTH];
    logic [7:0] m_acc  [NI];
    logic [3:0] m_pc   [NI];
    logic       m_halt [NI];
    string      m_tag  [NI];

    function automatic logic [IMG_W-1:0] img_of(input int i);
        case (i)
            0:       return IMG0;
            1:       return IMG1;
            2:       return IMG2;
            default: return IMG3;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset(input int i);
        logic [IMG_W-1:0] img;
        img = img_of(i);
        for (int j = 0; j < DEPTH; j++) m_mem[i][j] = img[j*DATA_W +: DATA_W];
        m_acc[i]  = 8'h00;
        m_pc[i]   = 4'h0;
        m_halt[i] = 1'b0;
    endtask

    // Instruction-level reference of R3..R9.
    task automatic model_step(input int i);
        logic [7:0] w;
        logic [3:0] a;
        if (m_halt[i]) begin
            m_tag[i] = "R8";
            return;
        end
        w = m_mem[i][m_pc[i]];
        a = w[3:0];
        m_pc[i] = m_pc[i] + 4'h1;
        case (w[7:4])
            4'h0: begin m_acc[i] = m_mem[i][a];                       m_tag[i] = "R3"; end
            4'h1: begin m_acc[i] = m_acc[i] + m_mem[i][a];            m_tag[i] = "R4"; end
            4'h2: begin m_acc[i] = m_acc[i] + {4'h0, a};              m_tag[i] = "R5"; end
            4'h3: begin m_acc[i] = m_acc[i] + m_mem[i][m_mem[i][a][3:0]]; m_tag[i] = "R6"; end
            4'h4: begin m_mem[i][a] = m_acc[i];                       m_tag[i] = "R7"; end
            4'hF: begin m_halt[i] = 1'b1;                             m_tag[i] = "R8"; end
            default: m_tag[i] = "R9";
        endcase
    endtask

    task automatic check_reset_state();
        for (int i = 0; i < NI; i++) begin
            check(acc_w[i] == 8'h00, "R1", "reset acc", acc_w[i], 0);
            check(pc_w[i] == 4'h0, "R1", "reset pc", pc_w[i], 0);
            check(halt_w[i] == 1'b0, "R1", "reset halted", halt_w[i], 0);
            check(state_w[i] == 3'd0, "R1", "reset state", state_w[i], 0);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        int unsigned hold;
        string tag;
        void'($urandom(32'd4242));
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state();

        for (int p = 0; p < 2; p++) begin
            if (p == 1) begin
                // second reset after the first run; random hold length
                rst  = 1'b1;
                hold = 1 + ($urandom % 4);
                repeat (hold) @(posedge clk);
                @(negedge clk);
                check_reset_state();
            end
            for (int i = 0; i < NI; i++) model_reset(i);
            rst = 1'b0;

            for (int k = 0; k < STEPS; k++) begin
                for (int i = 0; i < NI; i++) model_step(i);
                for (int c = 0; c < 8; c++) begin
                    @(negedge clk);
                    if (k == 1 && c <= 5)
                        check(acc_w[0] == 8'd5, "R10", "acc held before state 6 ends",
                              acc_w[0], 5);
                    if (k == 1 && c == 6)
                        check(acc_w[0] == 8'd12, "R6", "indirect sum after state 6",
                              acc_w[0], 12);
                    if (k == 3 && c == 2) begin
                        check(state_w[0] == 3'd3, "R8", "stop reaches state 3",
                              state_w[0], 3);
                        check(halt_w[0] == 1'b0, "R8", "not halted before state 3 ends",
                              halt_w[0], 0);
                    end
                    if (k == 3 && c >= 3) begin
                        check(halt_w[0] == 1'b1, "R8", "halted after state 3",
                              halt_w[0], 1);
                        check(state_w[0] == 3'd0, "R8", "state parked", state_w[0], 0);
                        check(pc_w[0] == 4'd4, "R8", "pc frozen", pc_w[0], 4);
                    end
                end
                for (int i = 0; i < NI; i++) begin
                    tag = (i == 0 && k <= 3) ? "R11" : m_tag[i];
                    check(acc_w[i] == m_acc[i], tag, $sformatf("acc inst %0d step %0d", i, k),
                          acc_w[i], m_acc[i]);
                    check(pc_w[i] == m_pc[i], m_halt[i] ? "R8" : "R2",
                          $sformatf("pc inst %0d step %0d", i, k), pc_w[i], m_pc[i]);
                    check(halt_w[i] == m_halt[i], "R8",
                          $sformatf("halted inst %0d step %0d", i, k), halt_w[i], m_halt[i]);
                    check(state_w[i] == 3'd0, "R2",
                          $sformatf("boundary state inst %0d step %0d", i, k), state_w[i], 0);
                end
                // R1: after the second reset the stored word at E is back to 11
                if (p == 1 && k == 4)
                    check(acc_w[1] == 8'h13, "R1", "image reloaded on reset", acc_w[1], 8'h13);
                // R7: the stored word is read back by the following load
                if (k == 6)
                    check(acc_w[1] == 8'h13, "R7", "stored word loaded back", acc_w[1], 8'h13);
            end
        end

        summary();
        $finish;
    end

endmodule